// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block drives a parallel RGB panel in data-enable mode. It advances once per pixel clock through programmable horizontal and vertical timing. From the horizontal and vertical counts it produces horizontal sync, vertical sync, a data-enable strobe and a pixel-clock enable. It pulls 24-bit pixels from an upstream stream through a valid/ready handshake. In each frame, active pixels start after the sync pulse and the back porch on both axes. Whatever is left of the programmed total forms the front porch.

Pixels pass through a small colour stage on their way out. Each output channel can take its colour from any input channel. The bits inside each component can be reversed. Low-order bits can be dropped to suit 6-bit, 8-bit or 5-6-5 panels. Each of the four control outputs has its own polarity flip. The timing values are captured only at a frame boundary, so software can rewrite them at any moment without tearing the frame in progress.

Top module: `rgb_timing_gen`

## Requirements
- R1: A line lasts exactly `cfg_h_total` pixel cycles and a frame exactly `cfg_v_total` lines; counting restarts at pixel 0 of line 0 after the last pixel of the last line.
- R2: Before inversion, hsync is high for pixels 0 .. `cfg_hs_width`-1 of each line, and vsync is high for all pixels of lines 0 .. `cfg_vs_width`-1.
- R3: Data enable is high only when the pixel index lies in [hs_width+h_back, hs_width+h_back+h_active) and the line index lies in [vs_width+v_back, vs_width+v_back+v_active). `pix_ready` is high in exactly those cycles, and the enable follows one cycle later.
- R4: `out_data` is zero whenever data enable is low, and also when the accepted cycle had `pix_valid` low. Otherwise it carries the shaped input pixel one cycle after `pix_ready`.
- R5: `cfg_inv_hs`, `cfg_inv_vs`, `cfg_inv_de` and `cfg_inv_pclk` each flip only their own output. The pixel-clock enable is 1 (before inversion) while timing runs.
- R6: Pixels are {R[23:16], G[15:8], B[7:0]}. Each output channel's 2-bit source code selects the channel: 0 = its own channel, 1 = red, 2 = green, 3 = blue.
- R7: When `cfg_bit_flip` is 1, bit i of every output component takes bit 7-i of the selected component. Selection happens first.
- R8: Format code `cfg_fmt`: 0 (10-bit) and 2 (8-bit) pass all 8 bits. 1 (6-bit) zeroes the low 2 bits of each component. 3 (565) zeroes the low 3 bits of red and blue and the low 2 bits of green. Formatting is applied after reversal.
- R9: Timing inputs written during a frame do not change that frame; they take effect from the next frame's pixel 0.
- R10: `underflow` becomes 1 in the cycle after any cycle with `pix_ready` high and `pix_valid` low. It then stays 1 until reset. A low `pix_valid` while `pix_ready` is low has no effect on it.
- R11: While `rst_n` is low (synchronous), all outputs are 0 including `pix_ready` and `underflow`. The first edge after release captures the timing, and pixel 0 of line 0 is presented on the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_hs_width | input | 12 | Horizontal sync width in pixels |
| cfg_h_back | input | 12 | Horizontal back porch |
| cfg_h_active | input | 12 | Active pixels per line |
| cfg_h_total | input | 12 | Pixels per line |
| cfg_vs_width | input | 12 | Vertical sync width in lines |
| cfg_v_back | input | 12 | Vertical back porch |
| cfg_v_active | input | 12 | Active lines per frame |
| cfg_v_total | input | 12 | Lines per frame |
| cfg_inv_hs | input | 1 | Invert hsync |
| cfg_inv_vs | input | 1 | Invert vsync |
| cfg_inv_de | input | 1 | Invert data enable |
| cfg_inv_pclk | input | 1 | Invert pixel-clock enable |
| cfg_src_r | input | 2 | Source of red output |
| cfg_src_g | input | 2 | Source of green output |
| cfg_src_b | input | 2 | Source of blue output |
| cfg_bit_flip | input | 1 | Reverse bit order in each component |
| cfg_fmt | input | 2 | Output depth code |
| pix_valid | input | 1 | Upstream pixel valid |
| pix_data | input | 24 | Upstream pixel {R,G,B} |
| pix_ready | output | 1 | Pixel taken this cycle |
| out_hsync | output | 1 | Horizontal sync |
| out_vsync | output | 1 | Vertical sync |
| out_de | output | 1 | Data enable |
| out_pclk_en | output | 1 | Pixel-clock enable |
| out_data | output | 24 | Shaped pixel |
| underflow | output | 1 | Sticky starvation flag |

## Verification
Five timing sets are driven. They differ in porch lengths, with one zero back porch, and each pairs its own mix of polarity flips, source codes, reversal and depth code. Between them they separate the channel routing, the flip order against truncation, and each output's own polarity. A mid-frame rewrite of the timing shows whether the new values wait for the frame boundary. Valid is then dropped twice: once inside the active region, which must set the flag and blank one pixel, and once in blanking, which must leave the flag clear.

// File: rtl/rgb_tg_pkg.sv
package rgb_tg_pkg;
  localparam int CNT_W  = 12;
  localparam int COMP_W = 8;
  localparam int N_CH   = 3;
  localparam int PIX_W  = N_CH * COMP_W;

  typedef logic [COMP_W-1:0] comp_t;
  typedef logic [PIX_W-1:0]  pix_t;

  typedef enum logic [1:0] {SRC_SAME = 2'd0, SRC_RED = 2'd1, SRC_GRN = 2'd2, SRC_BLU = 2'd3} src_e;
  typedef enum logic [1:0] {FMT_10B = 2'd0, FMT_6B = 2'd1, FMT_8B = 2'd2, FMT_565 = 2'd3} fmt_e;

  typedef struct packed {
    logic [CNT_W-1:0] hs_w, h_bp, h_act, h_tot;
    logic [CNT_W-1:0] vs_w, v_bp, v_act, v_tot;
  } tg_timing_t;

  function automatic logic fn_in_window(input logic [CNT_W-1:0] cnt, input logic [CNT_W-1:0] sw,
                                        input logic [CNT_W-1:0] bp, input logic [CNT_W-1:0] len);
    logic [CNT_W+1:0] lo, hi, c;
    c  = {2'b00, cnt};
    lo = {2'b00, sw} + {2'b00, bp};
    hi = lo + {2'b00, len};
    return (c >= lo) && (c < hi);
  endfunction

  function automatic comp_t fn_pick(input src_e s, input int own, input comp_t r, input comp_t g, input comp_t b);
    case (s)
      SRC_RED: return r;
      SRC_GRN: return g;
      SRC_BLU: return b;
      default: return (own == 0) ? r : ((own == 1) ? g : b);
    endcase
  endfunction

  function automatic comp_t fn_flip(input comp_t x);
    comp_t y;
    for (int i = 0; i < COMP_W; i++) y[i] = x[COMP_W-1-i];
    return y;
  endfunction

  function automatic int fn_keep_bits(input fmt_e f, input int ch);
    case (f)
      FMT_6B:  return COMP_W - 2;
      FMT_565: return (ch == 1) ? COMP_W - 2 : COMP_W - 3;
      default: return COMP_W;
    endcase
  endfunction

  function automatic comp_t fn_trim(input comp_t x, input int keep);
    comp_t y;
    for (int i = 0; i < COMP_W; i++) y[i] = (i >= COMP_W - keep) ? x[i] : 1'b0;
    return y;
  endfunction
endpackage

// File: rtl/rgb_tg_counter.sv
module rgb_tg_counter
  import rgb_tg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  tg_timing_t       cfg_in,
  output tg_timing_t       tm,
  output logic             armed,
  output logic [CNT_W-1:0] hcnt,
  output logic [CNT_W-1:0] vcnt,
  output logic             frame_wrap
);
  logic line_end;

  assign line_end   = armed && (hcnt == tm.h_tot - 1'b1);
  assign frame_wrap = line_end && (vcnt == tm.v_tot - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      hcnt  <= '0;
      vcnt  <= '0;
      tm    <= '0;
    end else if (!armed) begin
      armed <= 1'b1;
      tm    <= cfg_in;
    end else if (line_end) begin
      hcnt <= '0;
      if (frame_wrap) begin
        vcnt <= '0;
        tm   <= cfg_in;
      end else begin
        vcnt <= vcnt + 1'b1;
      end
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end
endmodule

// File: rtl/rgb_tg_region.sv
module rgb_tg_region
  import rgb_tg_pkg::*;
(
  input  logic             armed,
  input  tg_timing_t       tm,
  input  logic [CNT_W-1:0] hcnt,
  input  logic [CNT_W-1:0] vcnt,
  output logic             hs_act,
  output logic             vs_act,
  output logic             act_now
);
  logic h_in, v_in;

  always_comb begin
    h_in    = fn_in_window(hcnt, tm.hs_w, tm.h_bp, tm.h_act);
    v_in    = fn_in_window(vcnt, tm.vs_w, tm.v_bp, tm.v_act);
    hs_act  = armed && (hcnt < tm.hs_w);
    vs_act  = armed && (vcnt < tm.vs_w);
    act_now = armed && h_in && v_in;
  end
endmodule

// File: rtl/rgb_tg_colour.sv
module rgb_tg_colour
  import rgb_tg_pkg::*;
(
  input  pix_t       pix_in,
  input  src_e       src_r,
  input  src_e       src_g,
  input  src_e       src_b,
  input  logic       bit_flip,
  input  fmt_e       fmt,
  output pix_t       pix_out
);
  comp_t comp_in [N_CH];
  src_e  src_sel [N_CH];

  always_comb begin
    for (int c = 0; c < N_CH; c++)
      comp_in[c] = pix_in[PIX_W-1-c*COMP_W -: COMP_W];
    src_sel[0] = src_r;
    src_sel[1] = src_g;
    src_sel[2] = src_b;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    comp_t picked, oriented;
    always_comb begin
      picked   = fn_pick(src_sel[c], c, comp_in[0], comp_in[1], comp_in[2]);
      oriented = bit_flip ? fn_flip(picked) : picked;
    end
    assign pix_out[PIX_W-1-c*COMP_W -: COMP_W] = fn_trim(oriented, fn_keep_bits(fmt, c));
  end
endmodule

// File: rtl/rgb_timing_gen.sv
module rgb_timing_gen
  import rgb_tg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_hs_width,
  input  logic [CNT_W-1:0] cfg_h_back,
  input  logic [CNT_W-1:0] cfg_h_active,
  input  logic [CNT_W-1:0] cfg_h_total,
  input  logic [CNT_W-1:0] cfg_vs_width,
  input  logic [CNT_W-1:0] cfg_v_back,
  input  logic [CNT_W-1:0] cfg_v_active,
  input  logic [CNT_W-1:0] cfg_v_total,
  input  logic             cfg_inv_hs,
  input  logic             cfg_inv_vs,
  input  logic             cfg_inv_de,
  input  logic             cfg_inv_pclk,
  input  logic [1:0]       cfg_src_r,
  input  logic [1:0]       cfg_src_g,
  input  logic [1:0]       cfg_src_b,
  input  logic             cfg_bit_flip,
  input  logic [1:0]       cfg_fmt,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  output logic             pix_ready,
  output logic             out_hsync,
  output logic             out_vsync,
  output logic             out_de,
  output logic             out_pclk_en,
  output logic [PIX_W-1:0] out_data,
  output logic             underflow
);
  tg_timing_t       cfg_tm, tm;
  logic             armed, frame_wrap;
  logic [CNT_W-1:0] hcnt, vcnt;
  logic             hs_act, vs_act, act_now;
  pix_t             shaped;

  assign cfg_tm = '{hs_w: cfg_hs_width, h_bp: cfg_h_back, h_act: cfg_h_active, h_tot: cfg_h_total,
                    vs_w: cfg_vs_width, v_bp: cfg_v_back, v_act: cfg_v_active, v_tot: cfg_v_total};

  rgb_tg_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_in     (cfg_tm),
    .tm         (tm),
    .armed      (armed),
    .hcnt       (hcnt),
    .vcnt       (vcnt),
    .frame_wrap (frame_wrap)
  );

  rgb_tg_region u_reg (
    .armed   (armed),
    .tm      (tm),
    .hcnt    (hcnt),
    .vcnt    (vcnt),
    .hs_act  (hs_act),
    .vs_act  (vs_act),
    .act_now (act_now)
  );

  rgb_tg_colour u_col (
    .pix_in   (pix_data),
    .src_r    (src_e'(cfg_src_r)),
    .src_g    (src_e'(cfg_src_g)),
    .src_b    (src_e'(cfg_src_b)),
    .bit_flip (cfg_bit_flip),
    .fmt      (fmt_e'(cfg_fmt)),
    .pix_out  (shaped)
  );

  assign pix_ready = act_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_hsync   <= 1'b0;
      out_vsync   <= 1'b0;
      out_de      <= 1'b0;
      out_pclk_en <= 1'b0;
      out_data    <= '0;
      underflow   <= 1'b0;
    end else begin
      out_hsync   <= hs_act  ^ cfg_inv_hs;
      out_vsync   <= vs_act  ^ cfg_inv_vs;
      out_de      <= act_now ^ cfg_inv_de;
      out_pclk_en <= armed   ^ cfg_inv_pclk;
      out_data    <= (act_now && pix_valid) ? shaped : '0;
      if (act_now && !pix_valid) underflow <= 1'b1;
    end
  end
endmodule

// File: rtl/rgb_tg_checker.sv
module rgb_tg_checker
  import rgb_tg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             pix_ready,
  input logic             pix_valid,
  input logic             underflow,
  input logic             out_de,
  input logic             cfg_inv_de,
  input logic [PIX_W-1:0] out_data,
  input logic [1:0]       cfg_fmt,
  input logic             frame_wrap,
  input logic [CNT_W-1:0] hcnt,
  input logic [CNT_W-1:0] vcnt
);
  AST_READY_LEADS_DE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |=> (out_de != cfg_inv_de)); // R3
  AST_IDLE_LEADS_NO_DE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_ready && $stable(cfg_inv_de)) |=> (out_de == cfg_inv_de)); // R3
  AST_BLANK_OUTSIDE_DE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_de == cfg_inv_de) |-> (out_data == '0)); // R4
  AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow); // R10
  AST_UF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ready && !pix_valid) |=> underflow); // R10
  AST_FMT565_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fmt == 2'd3 && $stable(cfg_fmt)) |-> (out_data[18:16] == 3'd0 && out_data[9:8] == 2'd0 && out_data[2:0] == 3'd0)); // R8
  AST_FMT6_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fmt == 2'd1 && $stable(cfg_fmt)) |-> (out_data[17:16] == 2'd0 && out_data[9:8] == 2'd0 && out_data[1:0] == 2'd0)); // R8
  AST_WRAP_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (hcnt == '0 && vcnt == '0)); // R1
endmodule

bind rgb_timing_gen rgb_tg_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_ready  (pix_ready),
  .pix_valid  (pix_valid),
  .underflow  (underflow),
  .out_de     (out_de),
  .cfg_inv_de (cfg_inv_de),
  .out_data   (out_data),
  .cfg_fmt    (cfg_fmt),
  .frame_wrap (frame_wrap),
  .hcnt       (hcnt),
  .vcnt       (vcnt)
);

// File: tb/tb_rgb_timing_gen.sv
module tb_rgb_timing_gen;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] hsw, hbp, hact, htot, vsw, vbp, vact, vtot;
    logic [3:0] inv;   // {pclk, de, vs, hs}
    logic [1:0] sr, sg, sb;
    logic       flip;
    logic [1:0] fmt;
  } vec_t;

  localparam vec_t VT [5] = '{
    '{8'd2, 8'd2, 8'd6, 8'd12, 8'd1, 8'd1, 8'd4, 8'd7, 4'b0000, 2'd0, 2'd0, 2'd0, 1'b0, 2'd0},
    '{8'd2, 8'd2, 8'd6, 8'd12, 8'd1, 8'd1, 8'd4, 8'd7, 4'b0001, 2'd3, 2'd1, 2'd2, 1'b0, 2'd2},
    '{8'd1, 8'd3, 8'd5, 8'd10, 8'd2, 8'd1, 8'd3, 8'd8, 4'b0110, 2'd0, 2'd0, 2'd0, 1'b1, 2'd1},
    '{8'd3, 8'd1, 8'd8, 8'd14, 8'd1, 8'd2, 8'd5, 8'd9, 4'b1000, 2'd2, 2'd2, 2'd2, 1'b0, 2'd3},
    '{8'd2, 8'd0, 8'd4, 8'd8,  8'd1, 8'd0, 8'd2, 8'd4, 4'b1111, 2'd1, 2'd3, 2'd0, 1'b1, 2'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] c_hsw, c_hbp, c_hact, c_htot, c_vsw, c_vbp, c_vact, c_vtot;
  logic c_ihs, c_ivs, c_ide, c_ipc, c_flip;
  logic [1:0] c_sr, c_sg, c_sb, c_fmt;
  logic pix_valid = 1'b1;
  logic [23:0] pix_data = 24'h0;
  logic pix_ready, o_hs, o_vs, o_de, o_pc, o_uf;
  logic [23:0] o_dat;

  int n_vec = 0, n_bad = 0;
  logic chk_en = 1'b0;
  string ph = "";
  logic [31:0] lcg = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  rgb_timing_gen dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_hs_width(c_hsw), .cfg_h_back(c_hbp), .cfg_h_active(c_hact), .cfg_h_total(c_htot),
    .cfg_vs_width(c_vsw), .cfg_v_back(c_vbp), .cfg_v_active(c_vact), .cfg_v_total(c_vtot),
    .cfg_inv_hs(c_ihs), .cfg_inv_vs(c_ivs), .cfg_inv_de(c_ide), .cfg_inv_pclk(c_ipc),
    .cfg_src_r(c_sr), .cfg_src_g(c_sg), .cfg_src_b(c_sb), .cfg_bit_flip(c_flip), .cfg_fmt(c_fmt),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .out_hsync(o_hs), .out_vsync(o_vs), .out_de(o_de), .out_pclk_en(o_pc),
    .out_data(o_dat), .underflow(o_uf)
  );

  // ---- independent reference model, written from the requirements ----
  function automatic logic [7:0] b_chan(input logic [1:0] code, input int own, input logic [23:0] d);
    int idx;
    idx = (code == 2'd0) ? own : int'(code) - 1;
    return d[23 - 8*idx -: 8];
  endfunction

  function automatic logic [7:0] b_rev(input logic [7:0] x);
    logic [7:0] y;
    for (int i = 0; i < 8; i++) y[7-i] = x[i];
    return y;
  endfunction

  function automatic logic [7:0] b_cut(input logic [7:0] x, input int drop);
    return (x >> drop) << drop;
  endfunction

  function automatic logic [23:0] b_shape(input logic [23:0] d);
    logic [7:0] ch [3];
    int drop;
    ch[0] = b_chan(c_sr, 0, d);
    ch[1] = b_chan(c_sg, 1, d);
    ch[2] = b_chan(c_sb, 2, d);
    for (int c = 0; c < 3; c++) begin
      if (c_flip) ch[c] = b_rev(ch[c]);
      drop = (c_fmt == 2'd1) ? 2 : (c_fmt == 2'd3) ? ((c == 1) ? 2 : 3) : 0;
      ch[c] = b_cut(ch[c], drop);
    end
    return {ch[0], ch[1], ch[2]};
  endfunction

  int m_h, m_v, s_hsw, s_hbp, s_hact, s_htot, s_vsw, s_vbp, s_vact, s_vtot;
  logic m_arm, m_rdy, e_hs, e_vs, e_de, e_pc, e_uf;
  logic [23:0] e_dat;

  function automatic logic b_active(input int h, input int v);
    return (h >= s_hsw + s_hbp) && (h < s_hsw + s_hbp + s_hact) &&
           (v >= s_vsw + s_vbp) && (v < s_vsw + s_vbp + s_vact);
  endfunction

  task automatic b_latch();
    s_hsw = int'(c_hsw); s_hbp = int'(c_hbp); s_hact = int'(c_hact); s_htot = int'(c_htot);
    s_vsw = int'(c_vsw); s_vbp = int'(c_vbp); s_vact = int'(c_vact); s_vtot = int'(c_vtot);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_arm = 0; m_h = 0; m_v = 0; m_rdy = 0;
      e_hs = 0; e_vs = 0; e_de = 0; e_pc = 0; e_dat = '0; e_uf = 0;
    end else begin
      if (m_rdy && !pix_valid) e_uf = 1;
      if (!m_arm) begin
        e_hs = c_ihs; e_vs = c_ivs; e_de = c_ide; e_pc = c_ipc; e_dat = '0;
        m_arm = 1; m_h = 0; m_v = 0;
        b_latch();
      end else begin
        e_hs  = (m_h < s_hsw) ^ c_ihs;
        e_vs  = (m_v < s_vsw) ^ c_ivs;
        e_de  = m_rdy ^ c_ide;
        e_pc  = 1'b1 ^ c_ipc;
        e_dat = (m_rdy && pix_valid) ? b_shape(pix_data) : '0;
        if (m_h == s_htot - 1) begin
          m_h = 0;
          if (m_v == s_vtot - 1) begin m_v = 0; b_latch(); end
          else m_v = m_v + 1;
        end else m_h = m_h + 1;
      end
      m_rdy = b_active(m_h, m_v);
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s %s: actual %h expected %h at %0t", req, what, ph, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      chk("R1,R2", "hsync", o_hs, e_hs);
      chk("R1,R2", "vsync", o_vs, e_vs);
      chk("R3", "de", o_de, e_de);
      chk("R3", "ready", pix_ready, m_rdy);
      chk("R5", "pclk_en", o_pc, e_pc);
      chk("R4,R6,R7,R8", "data", o_dat, e_dat);
      chk("R10", "underflow", o_uf, e_uf);
    end
    lcg = lcg * 32'd1103515245 + 32'd12345;
    pix_data <= lcg[31:8];
  end

  task automatic load_vec(input vec_t v);
    c_hsw = 12'(v.hsw); c_hbp = 12'(v.hbp); c_hact = 12'(v.hact); c_htot = 12'(v.htot);
    c_vsw = 12'(v.vsw); c_vbp = 12'(v.vbp); c_vact = 12'(v.vact); c_vtot = 12'(v.vtot);
    {c_ipc, c_ide, c_ivs, c_ihs} = v.inv;
    c_sr = v.sr; c_sg = v.sg; c_sb = v.sb; c_flip = v.flip; c_fmt = v.fmt;
  endtask

  task automatic restart(input vec_t v);
    @(negedge clk);
    chk_en = 1'b0;
    rst_n = 1'b0;
    pix_valid = 1'b1;
    load_vec(v);
    repeat (2) @(negedge clk);
    // R11: every output is 0 during reset, whatever the polarity settings
    chk("R11", "reset outs", {o_hs, o_vs, o_de, o_pc, pix_ready, o_uf}, 6'b0);
    chk("R11", "reset data", o_dat, 24'h0);
    rst_n = 1'b1;
    chk_en = 1'b1;
  endtask

  initial begin
    load_vec(VT[0]);
    // main table, two full frames per entry
    for (int i = 0; i < 5; i++) begin
      ph = $sformatf("[table %0d R1 R2 R3 R5 R6 R7 R8]", i);
      restart(VT[i]);
      repeat (2 * int'(VT[i].htot) * int'(VT[i].vtot) + 4) @(negedge clk);
    end

    // R9: timing rewritten mid-frame must wait for the next frame
    ph = "[reprogram R9]";
    restart(VT[0]);
    repeat (40) @(negedge clk);
    c_hsw = 12'd1; c_hbp = 12'd3; c_hact = 12'd5; c_htot = 12'd10;
    c_vsw = 12'd2; c_vbp = 12'd1; c_vact = 12'd3; c_vtot = 12'd8;
    repeat (12*7 + 2*10*8) @(negedge clk);

    // R10: valid low during blanking leaves the flag clear
    ph = "[idle drop R10]";
    restart(VT[0]);
    pix_valid = 1'b0;
    repeat (5) @(negedge clk);
    pix_valid = 1'b1;
    @(negedge clk);
    chk("R10", "flag after blank drop", o_uf, 1'b0);

    // R10 / R4: valid low during active sets the flag and blanks that pixel
    ph = "[active drop R4 R10]";
    while (!pix_ready) @(negedge clk);
    pix_valid = 1'b0;
    @(negedge clk);
    pix_valid = 1'b1;
    chk("R4", "blanked pixel", o_dat, 24'h0);
    chk("R10", "flag set", o_uf, 1'b1);
    repeat (30) @(negedge clk);
    chk("R10", "flag held", o_uf, 1'b1);

    // R11: reset clears the flag
    ph = "[reset clears R11]";
    restart(VT[0]);
    chk_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11", "flag after reset", o_uf, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule